// File: doc/BRIEF.md
# Multicycle Functional-Unit Issue Checker

This block sits in the decode stage of an in-order pipeline whose execute side has four kinds of unit. An integer unit handles ALU work and memory access. A multiplier and a floating-point adder are fully pipelined. A divider is not pipelined. Each cycle the block looks at the instruction waiting in decode: its unit code, its two source register numbers, its destination register number, and whether it writes that destination. It then decides in the same cycle whether the instruction may issue into execute. If it may not, it raises a stall, and the decode stage holds that instruction and everything behind it.

The decision combines three checks. The structural check asks whether the selected unit can accept work this cycle and whether the single register-file write port is free in the exact cycle the result would land. The read-after-write check asks whether either source still waits for an earlier result. The write-after-write check asks whether an earlier, slower operation to the same destination would complete after this one. State is kept in three places: a countdown per register, a busy countdown per unit whose initiation interval is greater than one, and a shift register with one write-port reservation per future cycle. The head of that shift register is reported as the writeback strobe and destination.

Top module: `mc_issue_checker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `wb_valid_o` is low. After reset no register, unit or write slot is reserved, so any instruction issues with no stall.
- R2: `issue_o` and `stall_o` are both low when `dec_valid_i` is low. When it is high, exactly one of them is high in that same cycle, and `issue_o` is high exactly when no hazard exists.
- R3: Unit codes are: 0 integer ALU (latency 0), 1 memory access (latency 1), 2 FP add (latency 3), 3 multiply (latency 6), 4 divide (latency 24). A consumer whose `dec_src_a_i` or `dec_src_b_i` names the destination of a producer issued in cycle t may issue no earlier than cycle t+1+latency. It issues exactly then if nothing else blocks it.
- R4: After a divide issues in cycle t, a second divide is refused until cycle t+25.
- R5: Integer, memory, FP-add and multiply operations with independent registers and distinct writeback cycles issue in back-to-back cycles.
- R6: A writing instruction of latency L is refused while an earlier writer of the same destination would complete after cycle now+1+L. Out-of-order completion to different destinations is not blocked.
- R7: A writing instruction that issues in cycle t with latency L raises `wb_valid_o` for exactly the one cycle t+1+L, with `wb_dst_o` equal to its destination.
- R8: A writing instruction is refused if another issued operation already holds the write port in its cycle t+1+L.
- R9: With `dec_wr_i` low, the instruction makes no write-port or register reservation, produces no writeback, and is not subject to the write-after-write or write-port checks. Its sources still get the read-after-write check.
- R10: Unit codes 5 to 7 behave as the integer ALU: latency 0 and never blocked by the divider.
- R11: A stalled instruction changes no reservation. Only issued instructions affect later decisions and writebacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid_i | input | 1 | An instruction is waiting in decode |
| dec_unit_i | input | 3 | Unit code of that instruction |
| dec_src_a_i | input | $clog2(REGS) | First source register |
| dec_src_b_i | input | $clog2(REGS) | Second source register |
| dec_dst_i | input | $clog2(REGS) | Destination register |
| dec_wr_i | input | 1 | Instruction writes its destination |
| issue_o | output | 1 | Instruction moves into execute at the coming edge |
| stall_o | output | 1 | Instruction and everything behind it hold |
| wb_valid_o | output | 1 | A result is written back this cycle |
| wb_dst_o | output | $clog2(REGS) | Register written back this cycle |

## Verification
The bench builds the block with its default parameters: 32 registers, latencies 0/1/3/6/24 and a divider interval of 25. These values make the 25-cycle divider window, the 24-cycle write-after-write wait behind a divide, and a write-port collision between a multiply and a later FP add all reachable within a few hundred cycles. Three back-to-back multiplies followed by an FP add walk the add across three occupied write slots. A non-writing FP add placed on a taken slot, and a reset taken while a divide is in flight, show that reservations come only from writing, issued instructions.

// File: rtl/issue_pkg.sv
package issue_pkg;

  typedef enum logic [2:0] {
    U_ALU  = 3'd0,
    U_MEM  = 3'd1,
    U_FADD = 3'd2,
    U_MUL  = 3'd3,
    U_DIV  = 3'd4
  } unit_e;

  localparam int NUM_UNITS = 5;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/issue_unit_busy.sv
// Initiation-interval guard for one execution unit.
module issue_unit_busy #(
  parameter int II = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  output logic busy_o
);

  if (II > 1) begin : g_cnt
    localparam int CW = $clog2(II);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst)              cnt_q <= '0;
      else if (take_i)      cnt_q <= CW'(II - 1);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
  end else begin : g_pipelined
    logic unused_in;
    assign unused_in = ^{clk, rst, take_i};
    assign busy_o    = 1'b0;
  end

endmodule

// File: rtl/issue_reg_pending.sv
// Per-register countdown of cycles until the pending result is usable.
module issue_reg_pending #(
  parameter int REGS = 32,
  parameter int RW   = 5,
  parameter int LATW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_i,
  input  logic [RW-1:0]   set_idx_i,
  input  logic [LATW-1:0] set_val_i,
  input  logic [RW-1:0]   rd_a_i,
  input  logic [RW-1:0]   rd_b_i,
  input  logic [RW-1:0]   rd_d_i,
  output logic [LATW-1:0] cnt_a_o,
  output logic [LATW-1:0] cnt_b_o,
  output logic [LATW-1:0] cnt_d_o
);

  logic [LATW-1:0] cnt_q [REGS];

  for (genvar r = 0; r < REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  cnt_q[r] <= '0;
      else if (set_i && set_idx_i == RW'(r))    cnt_q[r] <= set_val_i;
      else if (cnt_q[r] != '0)                  cnt_q[r] <= cnt_q[r] - 1'b1;
    end
  end

  assign cnt_a_o = cnt_q[rd_a_i];
  assign cnt_b_o = cnt_q[rd_b_i];
  assign cnt_d_o = cnt_q[rd_d_i];

endmodule

// File: rtl/issue_wb_slots.sv
// One reservation per future cycle for the single register-file write port.
module issue_wb_slots #(
  parameter int SLOTS = 25,
  parameter int RW    = 5,
  parameter int LATW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            claim_i,
  input  logic [LATW-1:0] lat_i,
  input  logic [RW-1:0]   dst_i,
  output logic            taken_o,
  output logic            wb_valid_o,
  output logic [RW-1:0]   wb_dst_o
);

  logic [SLOTS-1:0] v_q;
  logic [RW-1:0]    d_q [SLOTS];

  // A claim of latency L lands at post-shift index L, i.e. pre-shift index L+1.
  always_comb begin
    taken_o = 1'b0;
    for (int i = 1; i < SLOTS; i++) begin
      if (int'(lat_i) + 1 == i) taken_o = v_q[i];
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < SLOTS - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[i] <= 1'b0;
        end else if (claim_i && lat_i == LATW'(i)) begin
          v_q[i] <= 1'b1;
          d_q[i] <= dst_i;
        end else begin
          v_q[i] <= v_q[i+1];
          d_q[i] <= d_q[i+1];
        end
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[i] <= 1'b0;
        end else if (claim_i && lat_i == LATW'(i)) begin
          v_q[i] <= 1'b1;
          d_q[i] <= dst_i;
        end else begin
          v_q[i] <= 1'b0;
        end
      end
    end
  end

  assign wb_valid_o = v_q[0];
  assign wb_dst_o   = d_q[0];

endmodule

// File: rtl/mc_issue_checker.sv
module mc_issue_checker
  import issue_pkg::*;
#(
  parameter int REGS     = 32,
  parameter int LAT_ALU  = 0,
  parameter int LAT_MEM  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_MUL  = 6,
  parameter int LAT_DIV  = 24,
  parameter int II_MEM   = 1,
  parameter int II_FADD  = 1,
  parameter int II_MUL   = 1,
  parameter int II_DIV   = 25,
  parameter int RW       = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid_i,
  input  logic [2:0]    dec_unit_i,
  input  logic [RW-1:0] dec_src_a_i,
  input  logic [RW-1:0] dec_src_b_i,
  input  logic [RW-1:0] dec_dst_i,
  input  logic          dec_wr_i,
  output logic          issue_o,
  output logic          stall_o,
  output logic          wb_valid_o,
  output logic [RW-1:0] wb_dst_o
);

  localparam int MAX_LAT = imax(imax(imax(LAT_ALU, LAT_MEM), imax(LAT_FADD, LAT_MUL)), LAT_DIV);
  localparam int LATW    = (MAX_LAT < 1) ? 1 : $clog2(MAX_LAT + 1);
  localparam int SLOTS   = MAX_LAT + 1;
  localparam int II_TAB [NUM_UNITS] = '{1, II_MEM, II_FADD, II_MUL, II_DIV};

  logic [2:0]           unit_sel;
  logic [LATW-1:0]      lat_sel;
  logic [NUM_UNITS-1:0] unit_busy;
  logic [LATW-1:0]      cnt_a, cnt_b, cnt_d;
  logic                 slot_taken;
  logic                 haz_struct, haz_raw, haz_waw, hazard;
  logic                 wr_go;

  // Unused codes fall back to the integer ALU.
  assign unit_sel = (dec_unit_i > 3'(U_DIV)) ? 3'(U_ALU) : dec_unit_i;

  always_comb begin
    case (unit_sel)
      3'(U_MEM):  lat_sel = LATW'(LAT_MEM);
      3'(U_FADD): lat_sel = LATW'(LAT_FADD);
      3'(U_MUL):  lat_sel = LATW'(LAT_MUL);
      3'(U_DIV):  lat_sel = LATW'(LAT_DIV);
      default:    lat_sel = LATW'(LAT_ALU);
    endcase
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    issue_unit_busy #(.II(II_TAB[u])) u_busy (
      .clk    (clk),
      .rst    (rst),
      .take_i (issue_o && unit_sel == 3'(u)),
      .busy_o (unit_busy[u])
    );
  end

  issue_reg_pending #(.REGS(REGS), .RW(RW), .LATW(LATW)) u_pending (
    .clk       (clk),
    .rst       (rst),
    .set_i     (wr_go),
    .set_idx_i (dec_dst_i),
    .set_val_i (lat_sel),
    .rd_a_i    (dec_src_a_i),
    .rd_b_i    (dec_src_b_i),
    .rd_d_i    (dec_dst_i),
    .cnt_a_o   (cnt_a),
    .cnt_b_o   (cnt_b),
    .cnt_d_o   (cnt_d)
  );

  issue_wb_slots #(.SLOTS(SLOTS), .RW(RW), .LATW(LATW)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .claim_i    (wr_go),
    .lat_i      (lat_sel),
    .dst_i      (dec_dst_i),
    .taken_o    (slot_taken),
    .wb_valid_o (wb_valid_o),
    .wb_dst_o   (wb_dst_o)
  );

  assign haz_struct = unit_busy[unit_sel] | (dec_wr_i & slot_taken);
  assign haz_raw    = (cnt_a != '0) | (cnt_b != '0);
  assign haz_waw    = dec_wr_i & (cnt_d > lat_sel);
  assign hazard     = haz_struct | haz_raw | haz_waw;

  assign issue_o = dec_valid_i & ~hazard;
  assign stall_o = dec_valid_i &  hazard;
  assign wr_go   = issue_o & dec_wr_i;

endmodule

// File: rtl/issue_checker_sva.sv
module issue_checker_sva #(
  parameter int RW      = 5,
  parameter int LAT_ALU = 0,
  parameter int II_DIV  = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_valid_i,
  input logic [2:0]    dec_unit_i,
  input logic [RW-1:0] dec_dst_i,
  input logic          dec_wr_i,
  input logic          issue_o,
  input logic          stall_o,
  input logic          wb_valid_o,
  input logic [RW-1:0] wb_dst_o
);

  localparam int GW = $clog2(II_DIV + 1);
  logic [GW-1:0] since_div_q;

  always_ff @(posedge clk) begin
    if (rst)                                     since_div_q <= GW'(II_DIV);
    else if (issue_o && dec_unit_i == 3'd4)      since_div_q <= GW'(1);
    else if (since_div_q != GW'(II_DIV))         since_div_q <= since_div_q + 1'b1;
  end

  a_r1_no_wb_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wb_valid_o);

  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(issue_o && stall_o));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |-> (!issue_o && !stall_o));

  a_r4_div_interval: assert property (@(posedge clk) disable iff (rst)
    (issue_o && dec_unit_i == 3'd4) |-> (int'(since_div_q) >= II_DIV));

  if (LAT_ALU == 0) begin : g_alu_wb
    a_r7_alu_next_wb: assert property (@(posedge clk) disable iff (rst)
      (issue_o && dec_wr_i && dec_unit_i == 3'd0) |=>
        (wb_valid_o && wb_dst_o == $past(dec_dst_i)));
  end

endmodule

bind mc_issue_checker issue_checker_sva #(
  .RW(RW), .LAT_ALU(LAT_ALU), .II_DIV(II_DIV)
) u_sva (
  .clk         (clk),
  .rst         (rst),
  .dec_valid_i (dec_valid_i),
  .dec_unit_i  (dec_unit_i),
  .dec_dst_i   (dec_dst_i),
  .dec_wr_i    (dec_wr_i),
  .issue_o     (issue_o),
  .stall_o     (stall_o),
  .wb_valid_o  (wb_valid_o),
  .wb_dst_o    (wb_dst_o)
);

// File: tb/mc_issue_checker_tb_top.sv
module mc_issue_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid_i = 1'b0;
  logic [2:0] dec_unit_i = '0;
  logic [4:0] dec_src_a_i = '0, dec_src_b_i = '0, dec_dst_i = '0;
  logic       dec_wr_i = 1'b0;
  logic       issue_o, stall_o, wb_valid_o;
  logic [4:0] wb_dst_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_issue_checker dut_i (
    .clk(clk), .rst(rst), .dec_valid_i(dec_valid_i), .dec_unit_i(dec_unit_i),
    .dec_src_a_i(dec_src_a_i), .dec_src_b_i(dec_src_b_i), .dec_dst_i(dec_dst_i),
    .dec_wr_i(dec_wr_i), .issue_o(issue_o), .stall_o(stall_o),
    .wb_valid_o(wb_valid_o), .wb_dst_o(wb_dst_o)
  );

  int checks = 0, errors = 0, cyc = 0, div_free = 0;
  int free_at [NREG];
  int wb_at [int];
  bit done = 0;

  function automatic int lat_of(input int u);
    case (u)
      1: return 1;
      2: return 3;
      3: return 6;
      4: return 24;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NREG; r++) free_at[r] = 0;
    wb_at.delete();
    div_free = 0;
    cyc = 0;
  endtask

  // One cycle: compare against the model, then advance it at the edge.
  task automatic step(output bit issued);
    int u, l;
    bit haz, exp_iss, exp_wb;
    #1;
    u = int'(dec_unit_i);
    l = lat_of(u);
    haz = (cyc < free_at[dec_src_a_i]) || (cyc < free_at[dec_src_b_i]);
    if (dec_wr_i && free_at[dec_dst_i] > cyc + l) haz = 1;
    if (dec_wr_i && wb_at.exists(cyc + 1 + l)) haz = 1;
    if (u == 4 && cyc < div_free) haz = 1;
    exp_iss = dec_valid_i && !haz;
    chk(issue_o == exp_iss, "R2", "issue_o", int'(issue_o), int'(exp_iss));
    chk(stall_o == (dec_valid_i && haz), "R2", "stall_o", int'(stall_o), int'(dec_valid_i && haz));
    exp_wb = wb_at.exists(cyc);
    chk(wb_valid_o == exp_wb, "R7", "wb_valid_o", int'(wb_valid_o), int'(exp_wb));
    if (exp_wb) chk(int'(wb_dst_o) == wb_at[cyc], "R7", "wb_dst_o", int'(wb_dst_o), wb_at[cyc]);
    issued = exp_iss;
    @(posedge clk);
    if (exp_iss) begin
      if (dec_wr_i) begin
        free_at[dec_dst_i] = cyc + 1 + l;
        wb_at[cyc + 1 + l] = int'(dec_dst_i);
      end
      if (u == 4) div_free = cyc + 25;
    end
    if (wb_at.exists(cyc)) wb_at.delete(cyc);
    cyc++;
    @(negedge clk);
  endtask

  task automatic send(input int u, input int a, input int b, input int d, input bit wr,
                      input string req, input int exp_stalls);
    bit iss;
    int n = 0;
    dec_valid_i = 1'b1; dec_unit_i = 3'(u);
    dec_src_a_i = 5'(a); dec_src_b_i = 5'(b); dec_dst_i = 5'(d); dec_wr_i = wr;
    for (int k = 0; k < 100; k++) begin
      step(iss);
      if (iss) break;
      n++;
    end
    chk(n == exp_stalls, req, "stall cycles", n, exp_stalls);
    dec_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    bit iss;
    dec_valid_i = 1'b0;
    repeat (n) step(iss);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      chk(!wb_valid_o, "R1", "wb_valid_o in reset", int'(wb_valid_o), 0);
      chk(!issue_o && !stall_o, "R1", "issue/stall in reset", int'(issue_o | stall_o), 0);
    end
    rst = 1'b0;
    model_reset();

    // R3, R5: integer back-to-back and latencies per unit
    send(0, 0, 0, 1, 1, "R5", 0);
    send(0, 1, 0, 2, 1, "R3", 0);
    send(3, 0, 0, 3, 1, "R5", 0);
    send(0, 3, 0, 4, 1, "R3", 6);
    send(1, 0, 0, 5, 1, "R5", 0);
    send(0, 0, 5, 6, 1, "R3", 1);
    send(2, 0, 0, 7, 1, "R5", 0);
    send(0, 7, 7, 8, 1, "R3", 3);

    // R5 pipelined multiplies, then R8 write-port collisions
    send(3, 0, 0, 9, 1, "R5", 0);
    send(3, 0, 0, 10, 1, "R5", 0);
    send(3, 0, 0, 11, 1, "R5", 0);
    send(2, 0, 0, 12, 1, "R8", 3);
    idle(10);

    // R4 divider interval, R6 write-after-write
    send(4, 0, 0, 13, 1, "R4", 0);
    send(4, 0, 0, 14, 1, "R4", 24);
    send(0, 0, 0, 14, 1, "R6", 24);
    send(4, 0, 0, 15, 1, "R6", 0);
    send(0, 0, 0, 16, 1, "R6", 0);
    send(3, 0, 0, 17, 1, "R6", 0);
    send(2, 0, 0, 17, 1, "R6", 3);
    idle(30);

    // R9 non-writing instructions; R11 via per-cycle model comparison
    send(3, 0, 0, 18, 1, "R9", 0);
    idle(2);
    send(2, 0, 0, 18, 0, "R9", 0);
    send(3, 0, 0, 19, 1, "R9", 0);
    send(1, 19, 0, 0, 0, "R9", 6);
    idle(10);

    // R10 spare codes act as integer ops, not blocked by the divider
    send(4, 0, 0, 20, 1, "R10", 0);
    send(6, 0, 0, 21, 1, "R10", 0);
    send(0, 21, 0, 22, 1, "R10", 0);
    send(7, 22, 0, 23, 1, "R10", 0);
    send(5, 23, 0, 24, 1, "R10", 0);

    // R1: reset while a divide is in flight clears everything
    rst = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(!wb_valid_o, "R1", "wb_valid_o in reset", int'(wb_valid_o), 0);
    end
    rst = 1'b0;
    model_reset();
    send(4, 0, 0, 25, 1, "R1", 0);
    send(0, 20, 0, 26, 1, "R1", 0);
    send(0, 0, 0, 20, 1, "R1", 0);
    idle(30);

    done = 1;
    summary();
    $finish;
  end

endmodule